// File: doc/BRIEF.md
# Dual-Bank Flash Image Validator

This block inspects two copies of a non-volatile settings image that sit back to back in a byte-wide flash window. On a start pulse it reads every byte of bank 0 and then every byte of bank 1. It issues one address per cycle and takes the data one cycle later.

While the bytes stream past, it checks three things for each bank. The first is a marker byte. The second is an 8-bit header checksum whose carries are folded back in. The third is a 32-bit Adler-style sum over the body, reduced modulo 65521 as it goes. It also picks out the 32-bit generation counter. A bank that fails any check reports generation zero.

Once both banks have been scanned, the block names as active the bank with the larger generation and raises a one-cycle done pulse. Firmware uses that choice after power-up to find the newest intact copy of an A/B pair. The image size `IMG_BYTES` must be a power of two. Bank 1 occupies the `IMG_BYTES` addresses directly above bank 0.

The control sequence uses five states:

- IDLE goes to FETCH on start.
- FETCH issues reads. It goes to DRAIN after the bank's last address.
- DRAIN absorbs the final returning byte and then goes to JUDGE.
- JUDGE latches the bank's verdict. It goes back to FETCH for bank 1, or on to DONE after bank 1.
- DONE returns to IDLE after one cycle.

Top module: `nvram_bank_validator`

## Requirements
- R1: A start pulse in IDLE makes the block read addresses 0 to IMG_BYTES-1 and then IMG_BYTES to 2*IMG_BYTES-1. Each bank's addresses come on consecutive cycles with `rd_en` high, for 2*IMG_BYTES reads in total. `done` rises 2*IMG_BYTES+4 cycles after the edge that samples start.
- R2: `rd_data` is taken as the byte for the address that was presented with `rd_en` on the previous cycle.
- R3: A bank is valid only if its byte at offset 0 equals 8'h5A.
- R4: The header checksum is computed as follows:
  - Add byte 0 and bytes 2 through 15 as a 16-bit sum.
  - Repeatedly add the high byte to the low byte until the value fits in 8 bits.
  - The result must equal byte 1.
- R5: The body sum is computed over offsets 20 to IMG_BYTES-1 as follows:
  - low starts at 1 and high starts at 0.
  - For each byte, low = (low + byte) mod 65521, then high = (high + low) mod 65521.
  - {high, low} must equal the big-endian 32-bit word at offsets 16 to 19.
- R6: The generation is the big-endian 32-bit word at offsets 20 to 23, compared unsigned. A bank failing R3, R4 or R5 reports `bankN_ok` = 0 and generation 0.
- R7: `active_bank` is 1 only if bank 1's reported generation is strictly greater than bank 0's. Ties give 0.
- R8: The done pulse behaves as follows:
  - `done` is high for exactly one cycle.
  - The results hold until the next accepted start.
  - An accepted start clears the results to 0.
- R9: A start pulse outside IDLE, including during the done cycle, is ignored. It neither restarts nor extends the scan.
- R10: After reset, `done`, `rd_en`, both ok flags and both generations are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (honoured in IDLE only) |
| rd_en | output | 1 | Read strobe, one byte per cycle |
| rd_addr | output | $clog2(IMG_BYTES)+1 | Byte address; top bit selects the bank |
| rd_data | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | One-cycle scan-complete pulse |
| bank0_ok | output | 1 | Bank 0 passed all checks |
| bank1_ok | output | 1 | Bank 1 passed all checks |
| bank0_gen | output | 32 | Bank 0 generation, 0 if invalid |
| bank1_gen | output | 32 | Bank 1 generation, 0 if invalid |
| active_bank | output | 1 | Selected bank |

## Verification
Two things can land on the same cycle:

- In the done cycle, a start request can meet the state's automatic return to IDLE.
- Mid-scan, a start request can meet an active fetch.

The bench raises start exactly on the cycle it first sees `done`, and raises it again deep inside bank 0's fetch. It judges both cases at the ports: the read strobe must stay low afterwards, the read count must be exactly two banks' worth, and `done` must arrive on the nominal cycle. Results are judged against images whose checksums the bench computes with plain sums and a single final modulo, across a sweep of generations, ties, unsigned wrap and each single kind of corruption.

// File: rtl/nvv_pkg.sv
package nvv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_JUDGE,
        ST_DONE
    } nvv_state_e;

    localparam logic [7:0] NVV_MARKER    = 8'h5A;
    localparam int         NVV_MOD       = 65521;
    localparam int         NVV_HDR_END   = 16;
    localparam int         NVV_SUM_OFF   = 16;
    localparam int         NVV_GEN_OFF   = 20;
    localparam int         NVV_BODY_OFF  = 20;

    // Fold a 16-bit sum into 8 bits by end-around carry; two passes suffice.
    function automatic logic [7:0] nvv_fold(input logic [15:0] s);
        logic [15:0] t;
        t = s;
        for (int k = 0; k < 2; k++) begin
            t = {8'h00, t[7:0]} + {8'h00, t[15:8]};
        end
        return t[7:0];
    endfunction

endpackage

// File: rtl/nvv_hdr_sum.sv
module nvv_hdr_sum
    import nvv_pkg::*;
#(
    parameter int OFF_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vld,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       data,
    output logic             hdr_ok
);

    logic [15:0] sum_q;
    logic [7:0]  stored_q;
    logic        marker_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q    <= '0;
            stored_q <= '0;
            marker_q <= 1'b0;
        end else if (vld) begin
            if (off == '0) begin
                marker_q <= (data == NVV_MARKER);
                sum_q    <= {8'h00, data};
            end else if (off == OFF_W'(1)) begin
                stored_q <= data;
            end else if (off < OFF_W'(NVV_HDR_END)) begin
                sum_q <= sum_q + {8'h00, data};
            end
        end
    end

    assign hdr_ok = marker_q && (nvv_fold(sum_q) == stored_q);

    // R4
    hsum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_q <= 16'd3825);

endmodule

// File: rtl/nvv_adler.sv
module nvv_adler
    import nvv_pkg::*;
#(
    parameter int OFF_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vld,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       data,
    output logic             sum_ok,
    output logic [31:0]      gen
);

    localparam logic [16:0] MOD17 = 17'(NVV_MOD);

    logic [15:0] low_q, high_q;
    logic [31:0] stored_q, gen_q;
    logic [16:0] low_sum, high_sum, low_red, high_red;

    always_comb begin
        low_sum  = {1'b0, low_q} + {9'h000, data};
        low_red  = (low_sum >= MOD17) ? low_sum - MOD17 : low_sum;
        high_sum = {1'b0, high_q} + low_red;
        high_red = (high_sum >= MOD17) ? high_sum - MOD17 : high_sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            low_q    <= 16'd1;
            high_q   <= '0;
            stored_q <= '0;
            gen_q    <= '0;
        end else if (vld) begin
            if (off >= OFF_W'(NVV_SUM_OFF) && off < OFF_W'(NVV_SUM_OFF + 4))
                stored_q <= {stored_q[23:0], data};
            if (off >= OFF_W'(NVV_GEN_OFF) && off < OFF_W'(NVV_GEN_OFF + 4))
                gen_q <= {gen_q[23:0], data};
            if (off >= OFF_W'(NVV_BODY_OFF)) begin
                low_q  <= low_red[15:0];
                high_q <= high_red[15:0];
            end
        end
    end

    assign sum_ok = ({high_q, low_q} == stored_q);
    assign gen    = gen_q;

    // R5
    adler_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q < 16'(NVV_MOD)) && (high_q < 16'(NVV_MOD)));

endmodule

// File: rtl/nvram_bank_validator.sv
module nvram_bank_validator
    import nvv_pkg::*;
#(
    parameter int IMG_BYTES = 8192
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    output logic                           rd_en,
    output logic [$clog2(IMG_BYTES):0]     rd_addr,
    input  logic [7:0]                     rd_data,
    output logic                           done,
    output logic                           bank0_ok,
    output logic                           bank1_ok,
    output logic [31:0]                    bank0_gen,
    output logic [31:0]                    bank1_gen,
    output logic                           active_bank
);

    localparam int               OFF_W = $clog2(IMG_BYTES);
    localparam logic [OFF_W-1:0] LAST  = OFF_W'(IMG_BYTES - 1);

    nvv_state_e       state_q, state_nx;
    logic [OFF_W-1:0] cnt_q, doff_q;
    logic             bank_q, dv_q, clr_acc;
    logic             hdr_ok, sum_ok, bank_pass;
    logic [31:0]      gen_raw;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_nx = ST_FETCH;
            ST_FETCH: if (cnt_q == LAST) state_nx = ST_DRAIN;
            ST_DRAIN: state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = bank_q ? ST_DONE : ST_FETCH;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign clr_acc   = ((state_q == ST_IDLE) && start) || (state_q == ST_JUDGE);
    assign bank_pass = hdr_ok && sum_ok;

    // Counters, pipeline and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bank_q    <= 1'b0;
            dv_q      <= 1'b0;
            doff_q    <= '0;
            bank0_ok  <= 1'b0;
            bank1_ok  <= 1'b0;
            bank0_gen <= '0;
            bank1_gen <= '0;
        end else begin
            dv_q   <= (state_q == ST_FETCH);
            doff_q <= cnt_q;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cnt_q     <= '0;
                    bank_q    <= 1'b0;
                    bank0_ok  <= 1'b0;
                    bank1_ok  <= 1'b0;
                    bank0_gen <= '0;
                    bank1_gen <= '0;
                end
                ST_FETCH: cnt_q <= cnt_q + 1'b1;
                ST_JUDGE: begin
                    if (bank_q) begin
                        bank1_ok  <= bank_pass;
                        bank1_gen <= bank_pass ? gen_raw : '0;
                    end else begin
                        bank0_ok  <= bank_pass;
                        bank0_gen <= bank_pass ? gen_raw : '0;
                        bank_q    <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    assign rd_en       = (state_q == ST_FETCH);
    assign rd_addr     = {bank_q, cnt_q};
    assign done        = (state_q == ST_DONE);
    assign active_bank = (bank1_gen > bank0_gen);

    nvv_hdr_sum #(.OFF_W(OFF_W)) hdr_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_acc), .vld(dv_q),
        .off(doff_q), .data(rd_data), .hdr_ok(hdr_ok)
    );

    nvv_adler #(.OFF_W(OFF_W)) adl_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_acc), .vld(dv_q),
        .off(doff_q), .data(rd_data), .sum_ok(sum_ok), .gen(gen_raw)
    );

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R6
    gen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((bank0_ok || bank0_gen == '0) && (bank1_ok || bank1_gen == '0)));

    // R7
    tie_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bank0_gen == bank1_gen) |-> !active_bank);

    // R9
    done_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rd_en);

endmodule

// File: tb/nvram_bank_validator_tb.sv
module nvram_bank_validator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 512;
    localparam int AW         = $clog2(N) + 1;
    localparam int EXP_CYC    = 2 * N + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;
    logic          done, ok0, ok1, act;
    logic [31:0]   g0, g1;

    logic [7:0] mem [0:2*N-1];
    int n_chk = 0, n_fail = 0;
    int exp_addr = 0, rd_cnt = 0, addr_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvram_bank_validator #(.IMG_BYTES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done),
        .bank0_ok(ok0), .bank1_ok(ok1), .bank0_gen(g0), .bank1_gen(g1),
        .active_bank(act)
    );

    // Flash model: registered read
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    // Address order monitor
    always @(negedge clk) begin
        if (rd_en) begin
            if (int'(rd_addr) != exp_addr) addr_err++;
            exp_addr++;
            rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic build(input int b, input logic [31:0] gen, input int seed);
        longint lo, hi;
        int s;
        int base = b * N;
        for (int i = 0; i < N; i++)
            mem[base+i] = (seed < 0) ? 8'hFF : 8'(i * seed + 3 * b + 11);
        mem[base+0] = 8'h5A;
        for (int k = 0; k < 4; k++) mem[base+20+k] = gen[31-8*k -: 8];
        lo = 1; hi = 0;
        for (int i = 20; i < N; i++) begin
            lo = lo + mem[base+i];
            hi = hi + lo;
        end
        lo = lo % 65521; hi = hi % 65521;
        for (int k = 0; k < 2; k++) mem[base+16+k] = 8'(hi >> (8 - 8*k));
        for (int k = 0; k < 2; k++) mem[base+18+k] = 8'(lo >> (8 - 8*k));
        s = mem[base+0];
        for (int i = 2; i < 16; i++) s = s + mem[base+i];
        while (s > 255) s = (s & 255) + (s >> 8);
        mem[base+1] = 8'(s);
    endtask

    // mid: extra start at cycle 100; collide: start in the done cycle;
    // clr: check results cleared early in the run
    task automatic run(input bit mid, input bit collide, input bit clr, input string tag);
        int n = 0;
        exp_addr = 0; rd_cnt = 0; addr_err = 0;
        @(negedge clk); start = 1'b1;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            start = 1'b0;
            if (mid && n == 100) start = 1'b1;
            if (clr && n == 5) begin
                chk(ok0 == 1'b0 && g0 == 32'd0, "R8", {tag, " cleared at start"}, g0, 0);
            end
            if (done) break;
            if (n > 5000) begin
                chk(1'b0, "R1", {tag, " watchdog"}, n, EXP_CYC);
                break;
            end
        end
        chk(n == EXP_CYC, "R1", {tag, " done latency"}, n, EXP_CYC);
        chk(rd_cnt == 2*N && addr_err == 0, "R1", {tag, " read order"}, rd_cnt + addr_err * 100000, 2*N);
        if (collide) start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R8", {tag, " done one cycle"}, done, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (collide) chk(rd_en == 1'b0, "R9", {tag, " no restart"}, rd_en, 0);
        end
    endtask

    task automatic expect_res(input bit e0, input bit e1, input logic [31:0] eg0,
                              input logic [31:0] eg1, input bit esel,
                              input string req, input string tag);
        chk(ok0 == e0, req, {tag, " bank0_ok"}, ok0, e0);
        chk(ok1 == e1, req, {tag, " bank1_ok"}, ok1, e1);
        chk(g0 == eg0, req, {tag, " bank0_gen"}, g0, eg0);
        chk(g1 == eg1, req, {tag, " bank1_gen"}, g1, eg1);
        chk(act == esel, "R7", {tag, " active_bank"}, act, esel);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 global watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 0 && rd_en == 0, "R10", "reset strobes", {done, rd_en}, 0);
        chk(ok0 == 0 && ok1 == 0 && g0 == 0 && g1 == 0, "R10", "reset results", g0 | g1, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 basic valid pair, bank 0 newer
        build(0, 32'd5, 3); build(1, 32'd3, 5);
        run(0, 0, 0, "basic");
        expect_res(1, 1, 5, 3, 0, "R2", "basic");
        repeat (10) @(negedge clk);
        chk(ok0 && ok1 && g0 == 5 && g1 == 3, "R8", "results held", g0, 5);

        // R7 bank 1 newer; R8 clearing
        build(0, 32'd3, 7); build(1, 32'd7, 9);
        run(0, 0, 1, "newer1");
        expect_res(1, 1, 3, 7, 1, "R7", "newer1");

        // R7 tie
        build(0, 32'd9, 1); build(1, 32'd9, 2);
        run(0, 0, 0, "tie");
        expect_res(1, 1, 9, 9, 0, "R7", "tie");

        // R5 corrupted body in bank 1
        build(0, 32'd2, 4); build(1, 32'd100, 6);
        mem[N+40] = mem[N+40] ^ 8'h01;
        run(0, 0, 0, "badbody");
        expect_res(1, 0, 2, 0, 0, "R5", "badbody");

        // R6 corrupted generation byte breaks the body sum too
        build(0, 32'd2, 4); build(1, 32'd100, 6);
        mem[N+23] = mem[N+23] ^ 8'h80;
        run(0, 0, 0, "badgen");
        expect_res(1, 0, 2, 0, 0, "R6", "badgen");

        // R3 bad marker in bank 0
        build(0, 32'd4, 8); build(1, 32'd1, 10);
        mem[0] = 8'h5B;
        run(0, 0, 0, "badmark");
        expect_res(0, 1, 0, 1, 1, "R3", "badmark");

        // R4 bad header checksum in bank 0
        build(0, 32'd8, 12); build(1, 32'd6, 13);
        mem[1] = mem[1] ^ 8'h04;
        run(0, 0, 0, "badhdr");
        expect_res(0, 1, 0, 6, 1, "R4", "badhdr");

        // R4/R5/R6 all-0xFF image (fold carries, modulo wrap), unsigned compare
        build(0, 32'h7FFF_FFFF, -1); build(1, 32'h8000_0001, -1);
        run(0, 0, 0, "wrap");
        expect_res(1, 1, 32'h7FFF_FFFF, 32'h8000_0001, 1, "R5", "wrap");

        // R9 start during fetch and during the done cycle
        build(0, 32'd11, 14); build(1, 32'd10, 15);
        run(1, 1, 0, "collide");
        expect_res(1, 1, 11, 10, 0, "R9", "collide");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule